// File: doc/BRIEF.md
# Front-End Readout Buffer Scheduler

This block decides when event data move out of a detector layer's front-end chips. It has no feedback from those chips about finished transfers. Instead it keeps its own model of their buffers and issues commands from that model. Each front end holds four event buffers, and the layer readout controller holds two. A trigger pulse stores an event in the next front-end buffer. The scheduler then issues a fill command, which moves one stored event into a controller buffer, where it is zero-suppressed. Later it issues a send command, which drains that controller buffer into the shared cable FIFO.

Up to two fill commands can be outstanding, one for each controller buffer. Further stored events wait inside the scheduler. A send goes out only while the cable FIFO occupancy is below a programmable threshold, and only one send is in flight at a time. A send is finished when the end-of-layer marker of the last chained layer is written into the FIFO. At that edge the front-end buffer and the controller buffer are both released. When all four front-end buffers are occupied the block raises dead time. A trigger that arrives during dead time is reported as rejected. A word written into an already full cable FIFO is reported as an overflow.

Top module: `fe_rd_sched`

## Requirements
- R1: After synchronous reset, every command, error and dead-time output is low, and all four front-end buffers and both controller buffers count as free.
- R2: A trigger that arrives while dead time is low is acknowledged one cycle later. The acknowledge reports the claimed front-end buffer index. Indices are claimed in the round-robin order 0, 1, 2, 3, 0.
- R3: dead_o is high exactly while all four front-end buffers are occupied. It rises with the acknowledge of the fourth stored event and falls at the edge where a send completes.
- R4: A trigger sampled while dead_o is high gives a trig_err_o pulse one cycle later. It is not acknowledged and does not change occupancy.
- R5: One cycle after a stored event exists that has no fill issued yet, and a controller buffer is free, fill_cmd_o pulses. With it come the front-end index (round-robin from 0) and the controller buffer index (alternating 0, 1, starting at 0).
- R6: At most two fill commands are outstanding. A third stored event gets its fill only one cycle after a send completes.
- R7: send_cmd_o pulses one cycle after a cycle in which no send is in flight, at least one fill is outstanding, and fifo_level_i < thresh_i. send_buf_o alternates 0, 1, starting at 0.
- R8: While fifo_level_i >= thresh_i, no send is issued, even when filled controller buffers wait.
- R9: A send completes when the ninth word carrying the end-of-layer flag (word_eol_i = 1) is written during that send. Words without the flag do not count. The next send is issued no earlier than one cycle after completion, once the level has been sampled again.
- R10: A word written (word_valid_i) while fifo_level_i equals the FIFO depth of 128 gives an ovf_err_o pulse one cycle later. Words written below that depth do not.
- R11: End-of-layer words written while no send is in flight are ignored. They do not shorten the count for the next send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger pulse, one per event |
| thresh_i | input | 8 | Almost-full threshold for the cable FIFO |
| fifo_level_i | input | 8 | Current cable FIFO occupancy |
| word_valid_i | input | 1 | A word is written into the cable FIFO |
| word_eol_i | input | 1 | The written word carries the end-of-layer flag |
| trig_ack_o | output | 1 | Trigger accepted |
| trig_slot_o | output | 2 | Front-end buffer claimed by the accepted trigger |
| trig_err_o | output | 1 | Trigger rejected during dead time |
| dead_o | output | 1 | All front-end buffers occupied |
| fill_cmd_o | output | 1 | Fill command pulse |
| fill_slot_o | output | 2 | Front-end buffer moved by the fill |
| fill_buf_o | output | 1 | Controller buffer targeted by the fill |
| send_cmd_o | output | 1 | Send command pulse |
| send_buf_o | output | 1 | Controller buffer drained by the send |
| ovf_err_o | output | 1 | Word written into a full cable FIFO |

## Verification
Every output is a register, so each result is due at a fixed edge after its cause. A trigger is acknowledged or rejected one cycle after it is sampled, its fill follows one cycle later, and its send follows one cycle after that if the level allows. After a completing end-of-layer word, the released fill slot and the next send both appear two cycles after that word was driven. For each stimulus the driver records the expected pulse together with its exact cycle number in a scoreboard. A negative-edge monitor matches every observed pulse against that cycle, so an early, late or extra pulse fails as surely as a wrong value. Dead time and the reset state are sampled at the negative edge of the cycle in which they are due.

// File: rtl/fe_rd_pkg.sv
package fe_rd_pkg;
  typedef enum logic {SND_IDLE, SND_BUSY} snd_state_t;
endpackage

// File: rtl/fe_rd_trk.sv
// Front-end buffer occupancy, round-robin claim, dead time.
module fe_rd_trk #(
  parameter int NBUF   = 4,
  parameter int SLOT_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              done_i,
  output logic [CNT_W-1:0]  occ_o,
  output logic              ack_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              err_o,
  output logic              dead_o
);
  localparam logic [CNT_W-1:0]  FULL = CNT_W'(NBUF);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NBUF - 1);

  logic [CNT_W-1:0]  occ_q, occ_d;
  logic [SLOT_W-1:0] wptr_q;
  logic              accept;

  assign accept = trig_i && (occ_q != FULL);
  assign occ_o  = occ_q;

  always_comb begin
    occ_d = occ_q;
    if (accept && !done_i)      occ_d = occ_q + CNT_W'(1);
    else if (!accept && done_i) occ_d = occ_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q  <= '0;
      wptr_q <= '0;
      ack_o  <= 1'b0;
      slot_o <= '0;
      err_o  <= 1'b0;
      dead_o <= 1'b0;
    end else begin
      occ_q  <= occ_d;
      ack_o  <= accept;
      err_o  <= trig_i && !accept;
      dead_o <= (occ_d == FULL);
      if (accept) begin
        slot_o <= wptr_q;
        wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fe_rd_fill.sv
// Issues fill commands against the controller buffers.
module fe_rd_fill #(
  parameter int NBUF   = 4,
  parameter int NRC    = 2,
  parameter int SLOT_W = 2,
  parameter int CNT_W  = 3,
  parameter int RC_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  occ_i,
  input  logic              done_i,
  output logic [CNT_W-1:0]  out_o,
  output logic              fill_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [RC_W-1:0]   buf_o
);
  localparam logic [CNT_W-1:0]  CAP   = CNT_W'(NRC);
  localparam logic [SLOT_W-1:0] SLAST = SLOT_W'(NBUF - 1);
  localparam logic [RC_W-1:0]   BLAST = RC_W'(NRC - 1);

  logic [CNT_W-1:0]  out_q;
  logic [SLOT_W-1:0] fptr_q;
  logic [RC_W-1:0]   bptr_q;
  logic              issue;

  assign issue = (occ_i > out_q) && (out_q < CAP);
  assign out_o = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      fptr_q <= '0;
      bptr_q <= '0;
      fill_o <= 1'b0;
      slot_o <= '0;
      buf_o  <= '0;
    end else begin
      fill_o <= issue;
      if (issue && !done_i)      out_q <= out_q + CNT_W'(1);
      else if (!issue && done_i) out_q <= out_q - CNT_W'(1);
      if (issue) begin
        slot_o <= fptr_q;
        buf_o  <= bptr_q;
        fptr_q <= (fptr_q == SLAST) ? '0 : fptr_q + SLOT_W'(1);
        bptr_q <= (bptr_q == BLAST) ? '0 : bptr_q + RC_W'(1);
      end
    end
  end
endmodule

// File: rtl/fe_rd_send.sv
// Issues send commands and detects their completion from the FIFO write stream.
module fe_rd_send
  import fe_rd_pkg::*;
#(
  parameter int NRC    = 2,
  parameter int NLAYER = 9,
  parameter int DEPTH  = 128,
  parameter int CNT_W  = 3,
  parameter int LVL_W  = 8,
  parameter int RC_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] out_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic             wvalid_i,
  input  logic             weol_i,
  output logic             send_o,
  output logic [RC_W-1:0]  buf_o,
  output logic             done_o,
  output logic             ovf_o
);
  localparam int              LAY_W = $clog2(NLAYER + 1);
  localparam logic [LAY_W-1:0] LLAST = LAY_W'(NLAYER - 1);
  localparam logic [RC_W-1:0]  BLAST = RC_W'(NRC - 1);
  localparam logic [LVL_W-1:0] FULL  = LVL_W'(DEPTH);

  snd_state_t       st_q;
  logic [LAY_W-1:0] eol_q;
  logic [RC_W-1:0]  sptr_q;
  logic             go;

  assign go     = (st_q == SND_IDLE) && (out_i != '0) && (level_i < thresh_i);
  assign done_o = (st_q == SND_BUSY) && wvalid_i && weol_i && (eol_q == LLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SND_IDLE;
      eol_q  <= '0;
      sptr_q <= '0;
      send_o <= 1'b0;
      buf_o  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      send_o <= go;
      ovf_o  <= wvalid_i && (level_i >= FULL);
      case (st_q)
        SND_IDLE: if (go) begin
          st_q   <= SND_BUSY;
          eol_q  <= '0;
          buf_o  <= sptr_q;
          sptr_q <= (sptr_q == BLAST) ? '0 : sptr_q + RC_W'(1);
        end
        SND_BUSY: if (wvalid_i && weol_i) begin
          if (eol_q == LLAST) st_q <= SND_IDLE;
          else                eol_q <= eol_q + LAY_W'(1);
        end
        default: st_q <= SND_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fe_rd_sched.sv
// Top: model-driven readout scheduler for one layer-end chain.
module fe_rd_sched #(
  parameter  int NBUF   = 4,
  parameter  int NRC    = 2,
  parameter  int NLAYER = 9,
  parameter  int DEPTH  = 128,
  localparam int SLOT_W = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int CNT_W  = $clog2(NBUF + 1),
  localparam int RC_W   = (NRC > 1) ? $clog2(NRC) : 1,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [LVL_W-1:0]  thresh_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic              word_valid_i,
  input  logic              word_eol_i,
  output logic              trig_ack_o,
  output logic [SLOT_W-1:0] trig_slot_o,
  output logic              trig_err_o,
  output logic              dead_o,
  output logic              fill_cmd_o,
  output logic [SLOT_W-1:0] fill_slot_o,
  output logic [RC_W-1:0]   fill_buf_o,
  output logic              send_cmd_o,
  output logic [RC_W-1:0]   send_buf_o,
  output logic              ovf_err_o
);
  logic [CNT_W-1:0] occ_w;
  logic [CNT_W-1:0] out_w;
  logic             done_w;

  fe_rd_trk #(.NBUF(NBUF), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst(rst), .trig_i(trig_i), .done_i(done_w), .occ_o(occ_w),
    .ack_o(trig_ack_o), .slot_o(trig_slot_o), .err_o(trig_err_o), .dead_o(dead_o)
  );

  fe_rd_fill #(.NBUF(NBUF), .NRC(NRC), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .RC_W(RC_W)) u_fill (
    .clk(clk), .rst(rst), .occ_i(occ_w), .done_i(done_w), .out_o(out_w),
    .fill_o(fill_cmd_o), .slot_o(fill_slot_o), .buf_o(fill_buf_o)
  );

  fe_rd_send #(.NRC(NRC), .NLAYER(NLAYER), .DEPTH(DEPTH), .CNT_W(CNT_W),
               .LVL_W(LVL_W), .RC_W(RC_W)) u_send (
    .clk(clk), .rst(rst), .out_i(out_w), .level_i(fifo_level_i), .thresh_i(thresh_i),
    .wvalid_i(word_valid_i), .weol_i(word_eol_i), .send_o(send_cmd_o),
    .buf_o(send_buf_o), .done_o(done_w), .ovf_o(ovf_err_o)
  );
endmodule

// File: rtl/fe_rd_sched_chk.sv
module fe_rd_sched_chk #(
  parameter int NBUF   = 4,
  parameter int NRC    = 2,
  parameter int DEPTH  = 128,
  parameter int SLOT_W = 2,
  parameter int LVL_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_i,
  input logic [LVL_W-1:0]  thresh_i,
  input logic [LVL_W-1:0]  fifo_level_i,
  input logic              word_valid_i,
  input logic              trig_ack_o,
  input logic [SLOT_W-1:0] trig_slot_o,
  input logic              trig_err_o,
  input logic              dead_o,
  input logic              fill_cmd_o,
  input logic              send_cmd_o,
  input logic              ovf_err_o,
  input logic              done_w
);
  logic [SLOT_W-1:0] last_q, exp_slot;
  logic              seen_q;
  int                outst_q;

  assign exp_slot = (last_q == SLOT_W'(NBUF - 1)) ? '0 : last_q + SLOT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      seen_q  <= 1'b0;
      outst_q <= 0;
    end else begin
      if (trig_ack_o) begin
        last_q <= trig_slot_o;
        seen_q <= 1'b1;
      end
      outst_q <= outst_q + (fill_cmd_o ? 1 : 0) - (done_w ? 1 : 0);
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (trig_i && !dead_o) |=> (trig_ack_o && !trig_err_o));
  assert_rr_order_R2: assert property (@(posedge clk) disable iff (rst)
    (trig_ack_o && seen_q) |-> (trig_slot_o == exp_slot));
  assert_dead_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dead_o) |-> $past(trig_i));
  assert_reject_R4: assert property (@(posedge clk) disable iff (rst)
    (trig_i && dead_o) |=> (trig_err_o && !trig_ack_o));
  assert_fill_cap_R6: assert property (@(posedge clk) disable iff (rst)
    (outst_q <= NRC));
  assert_one_send_R7: assert property (@(posedge clk) disable iff (rst)
    send_cmd_o |=> !send_cmd_o);
  assert_send_thresh_R8: assert property (@(posedge clk) disable iff (rst)
    send_cmd_o |-> ($past(fifo_level_i) < $past(thresh_i)));
  assert_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (word_valid_i && fifo_level_i == LVL_W'(DEPTH)) |=> ovf_err_o);
endmodule

bind fe_rd_sched fe_rd_sched_chk #(
  .NBUF(NBUF), .NRC(NRC), .DEPTH(DEPTH), .SLOT_W(SLOT_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .trig_i(trig_i), .thresh_i(thresh_i),
  .fifo_level_i(fifo_level_i), .word_valid_i(word_valid_i),
  .trig_ack_o(trig_ack_o), .trig_slot_o(trig_slot_o), .trig_err_o(trig_err_o),
  .dead_o(dead_o), .fill_cmd_o(fill_cmd_o), .send_cmd_o(send_cmd_o),
  .ovf_err_o(ovf_err_o), .done_w(done_w)
);

// File: tb/tb_fe_rd_sched.sv
`timescale 1ns/1ps
module tb_fe_rd_sched;
  localparam int K_ACK = 0, K_FILL = 1, K_SEND = 2, K_TERR = 3, K_OVF = 4;

  typedef struct {
    int    kind;
    int    val;
    int    cyc;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig = 1'b0;
  logic [7:0] thresh = 8'd8;
  logic [7:0] level = 8'd0;
  logic       wv = 1'b0, we = 1'b0;
  logic       ack, terr, dead, fill, send, ovf;
  logic [1:0] tslot, fslot;
  logic       fbuf, sbuf;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  fe_rd_sched dut (
    .clk(clk), .rst(rst), .trig_i(trig), .thresh_i(thresh), .fifo_level_i(level),
    .word_valid_i(wv), .word_eol_i(we), .trig_ack_o(ack), .trig_slot_o(tslot),
    .trig_err_o(terr), .dead_o(dead), .fill_cmd_o(fill), .fill_slot_o(fslot),
    .fill_buf_o(fbuf), .send_cmd_o(send), .send_buf_o(sbuf), .ovf_err_o(ovf)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic expect_item(input int k, input int v, input int c, input string r);
    exp_t e;
    e.kind = k; e.val = v; e.cyc = c; e.req = r;
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", r, cyc, act, exp);
    end
  endtask

  // Monitor: every observed pulse must match a scoreboard entry for this exact cycle.
  task automatic match(input int k, input int v, input string r);
    int idx = -1;
    for (int i = 0; i < q.size(); i++)
      if (idx < 0 && q[i].kind == k && q[i].cyc == cyc) idx = i;
    total++;
    if (idx < 0) begin
      bad++;
      $display("FAIL %s unexpected pulse kind=%0d cycle=%0d actual=%0d expected=none", r, k, cyc, v);
    end else begin
      if (q[idx].val != v) begin
        bad++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d", q[idx].req, k, cyc, v, q[idx].val);
      end
      q.delete(idx);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ack)  match(K_ACK,  int'(tslot), "R2");
      if (fill) match(K_FILL, int'(fslot) * 10 + int'(fbuf), "R5");
      if (send) match(K_SEND, int'(sbuf), "R7");
      if (terr) match(K_TERR, 0, "R4");
      if (ovf)  match(K_OVF,  0, "R10");
    end
  end

  task automatic words(input int nplain, input int neol, output int last);
    last = cyc;
    for (int i = 0; i < nplain + neol; i++) begin
      wv = 1'b1;
      we = (i >= nplain);
      last = cyc;
      @(negedge clk);
    end
    wv = 1'b0;
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    foreach (q[i]) begin
      total++;
      bad++;
      $display("FAIL %s missing pulse kind=%0d actual=none expected=%0d at cycle %0d",
               q[i].req, q[i].kind, q[i].val, q[i].cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, t, v, l;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(dead == 1'b0, "R1", int'(dead), 0);
    chk({ack, terr, fill, send, ovf} == 5'b0, "R1", int'({ack, terr, fill, send, ovf}), 0);

    // R11: end-of-layer words with no send in flight are ignored
    words(0, 5, l);
    idle(2);

    // R2/R5/R7: single event, level one below threshold (R8 boundary)
    level = 8'd7;
    c = cyc;
    expect_item(K_ACK, 0, c + 1, "R2");
    expect_item(K_FILL, 0, c + 2, "R5");
    expect_item(K_SEND, 0, c + 3, "R7");
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(dead == 1'b0, "R3", int'(dead), 0);
    idle(3);
    words(3, 9, l);
    idle(3);

    // R3/R4/R6/R8: fill four buffers while level is at threshold
    level = 8'd8;
    t = cyc;
    expect_item(K_ACK, 1, t + 1, "R2");
    expect_item(K_ACK, 2, t + 2, "R2");
    expect_item(K_ACK, 3, t + 3, "R2");
    expect_item(K_ACK, 0, t + 4, "R2");
    expect_item(K_FILL, 11, t + 2, "R5");
    expect_item(K_FILL, 20, t + 3, "R6");
    expect_item(K_TERR, 0, t + 5, "R4");
    trig = 1'b1;
    idle(3);
    chk(dead == 1'b0, "R3", int'(dead), 0);
    idle(1);
    chk(dead == 1'b1, "R3", int'(dead), 1);
    idle(1);
    trig = 1'b0;
    chk(dead == 1'b1, "R4", int'(dead), 1);
    idle(2);
    // R11: idle words while sends are held by the threshold
    words(0, 8, l);
    idle(3);
    chk(dead == 1'b1, "R8", int'(dead), 1);

    // R7: release the level, send for controller buffer 1
    c = cyc;
    expect_item(K_SEND, 1, c + 1, "R7");
    level = 8'd7;
    idle(3);
    // R9: eight flagged words leave the send open
    words(2, 8, l);
    chk(dead == 1'b1, "R9", int'(dead), 1);
    words(0, 1, v);
    chk(dead == 1'b0, "R9", int'(dead), 0);
    expect_item(K_FILL, 31, v + 2, "R6");
    expect_item(K_SEND, 0, v + 2, "R9");
    idle(3);
    words(0, 9, v);
    expect_item(K_FILL, 0, v + 2, "R6");
    expect_item(K_SEND, 1, v + 2, "R9");
    idle(3);
    words(0, 9, v);
    expect_item(K_SEND, 0, v + 2, "R9");
    idle(3);
    words(0, 9, v);
    idle(3);

    // R2/R5/R7: pointers wrap correctly on an empty pipeline
    c = cyc;
    expect_item(K_ACK, 1, c + 1, "R2");
    expect_item(K_FILL, 11, c + 2, "R5");
    expect_item(K_SEND, 1, c + 3, "R7");
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    idle(3);
    words(1, 9, v);
    idle(3);

    // R10: overflow at full depth, none one below
    level = 8'd128;
    c = cyc;
    expect_item(K_OVF, 0, c + 1, "R10");
    wv = 1'b1;
    @(negedge clk);
    level = 8'd127;
    @(negedge clk);
    wv = 1'b0;
    level = 8'd0;
    idle(4);
    chk(dead == 1'b0, "R3", int'(dead), 0);
    finish_run();
  end
endmodule